// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled by watching the two pulse trains that feed its phase-frequency detector: the divided reference and the divided feedback. Both pulse trains are sampled by a fast clock. For each rising edge, the block pairs it with the nearest edge of the other train, in either order, and measures the gap in fast-clock ticks. A pairing whose gap fits inside a selectable phase-error window counts as a good reference cycle. A pairing that does not close within the window counts as a bad one.

A lock flag rises once a programmed number of consecutive good cycles has been seen. There are two modes. In continuous mode, the first bad cycle drops the flag again. In latching mode, the flag holds once set until reset, which suits a start-up gate. The flag drives a status bit or an output pin directly.

Top module: `lockdet_top`

## Requirements
- R1: While `rstN` is low, `lockFlag` is 0 and the consecutive-good count is cleared, so after release a full lock count is needed again.
- R2: A rising edge of either `refIn` or `fbIn` opens a measurement, and the next rising edge of the other input closes it as a good cycle. The error is the number of fast-clock cycles between the two edges, and edges sampled in the same cycle have zero error. The feedback edge may come first.
- R3: The window holds up to `WIN_NARROW_TICKS` (default 3, standing for 15 ns at 200 MHz) when `winSel` is 0, and up to `WIN_WIDE_TICKS` (default 6, 30 ns) when `winSel` is 1. An error of window+1 ticks is a bad cycle.
- R4: When no closing edge arrives within the window, the open measurement is abandoned as a bad cycle. This covers a missing feedback pulse and a missing reference pulse.
- R5: `lockFlag` rises on the clock edge that records the Nth consecutive good cycle, with N = 2, 4, 8 or 16 for `lockTime` = 00, 01, 10 or 11. After N-1 good cycles the flag is still 0.
- R6: A bad cycle sets the consecutive-good count back to zero, so N fresh good cycles are needed after it.
- R7: With `latchMode` = 0, a bad cycle clears `lockFlag` on the clock edge that records it.
- R8: With `latchMode` = 1, a set `lockFlag` stays at 1 through bad cycles and missing pulses. It is cleared only by reset, or by a bad cycle after `latchMode` has returned to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, one tick of phase resolution |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Divided reference pulse train, sampled on `clk` |
| fbIn | input | 1 | Divided feedback pulse train, sampled on `clk` |
| winSel | input | 1 | Phase-error window: 0 narrow, 1 wide |
| lockTime | input | 2 | Required consecutive good cycles: 00=2, 01=4, 10=8, 11=16 |
| latchMode | input | 1 | 0 continuous monitoring, 1 hold flag after first lock |
| lockFlag | output | 1 | 1 when locked, 0 when not locked |

## Verification
A pairing state machine stuck open, or closed too early, turns good cycles into bad ones. In continuous mode this shows at `lockFlag` within one reference period, because the flag falls on the same edge as the bad verdict. A wrong consecutive-good count shows only when the flag rises one or more periods early or late, so the bench drives exactly N-1 and N good periods for every lock-time code and checks both sides. It also runs a behavioural reference model that predicts `lockFlag` on every clock, so an error of a single tick in the window boundary or in the flag timing is caught in the cycle where it first appears.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Rising edges seen this cycle on the two monitored pulse trains
  typedef struct packed {
    logic refRise;
    logic fbRise;
  } edge_t;

  // Strobes from the pairing control to the counting datapath
  typedef struct packed {
    logic goodStb;
    logic badStb;
  } verdict_t;

  typedef enum logic [1:0] {
    PAIR_IDLE     = 2'd0,
    PAIR_WAIT_FB  = 2'd1,
    PAIR_WAIT_REF = 2'd2
  } pair_state_t;

endpackage

// File: rtl/lockdet_edge.sv
module lockdet_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] pulseIn,
  output logic [N-1:0] riseOut
);

  logic [N-1:0] prevLevel;

  for (genvar i = 0; i < N; i++) begin : g_rise
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevLevel[i] <= 1'b0;
      else       prevLevel[i] <= pulseIn[i];
    end
    assign riseOut[i] = pulseIn[i] & ~prevLevel[i];
  end

endmodule

// File: rtl/lockdet_ctrl.sv
module lockdet_ctrl
  import lockdet_pkg::*;
#(
  parameter int WIN_NARROW_TICKS = 3,
  parameter int WIN_WIDE_TICKS   = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  edge_t    edges,
  input  logic     winSel,
  output verdict_t verdict
);

  localparam int AGE_W = $clog2(WIN_WIDE_TICKS + 1);

  pair_state_t pairState, pairNext;
  logic [AGE_W-1:0] age, ageNext;
  logic [AGE_W-1:0] winTicks;

  assign winTicks = winSel ? AGE_W'(WIN_WIDE_TICKS) : AGE_W'(WIN_NARROW_TICKS);

  always_comb begin
    pairNext = pairState;
    ageNext  = age;
    verdict  = '0;
    unique case (pairState)
      PAIR_IDLE: begin
        if (edges.refRise && edges.fbRise) begin
          verdict.goodStb = 1'b1;
        end else if (edges.refRise) begin
          pairNext = PAIR_WAIT_FB;
          ageNext  = AGE_W'(1);
        end else if (edges.fbRise) begin
          pairNext = PAIR_WAIT_REF;
          ageNext  = AGE_W'(1);
        end
      end
      PAIR_WAIT_FB: begin
        if (edges.fbRise) begin
          verdict.goodStb = 1'b1;
          pairNext = PAIR_IDLE;
        end else if (age >= winTicks) begin
          verdict.badStb = 1'b1;
          pairNext = PAIR_IDLE;
        end else begin
          ageNext = age + AGE_W'(1);
        end
      end
      PAIR_WAIT_REF: begin
        if (edges.refRise) begin
          verdict.goodStb = 1'b1;
          pairNext = PAIR_IDLE;
        end else if (age >= winTicks) begin
          verdict.badStb = 1'b1;
          pairNext = PAIR_IDLE;
        end else begin
          ageNext = age + AGE_W'(1);
        end
      end
      default: pairNext = PAIR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairState <= PAIR_IDLE;
      age       <= '0;
    end else begin
      pairState <= pairNext;
      age       <= ageNext;
    end
  end

  // R3: an open measurement never outlives the widest window
  p_age_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pairState != PAIR_IDLE) |-> (age >= AGE_W'(1) && age <= AGE_W'(WIN_WIDE_TICKS)));

  // R4: an open measurement always closes, so it cannot stay open two cycles at the wide limit
  p_close_at_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pairState != PAIR_IDLE && age >= winTicks) |=> (pairState == PAIR_IDLE || age == AGE_W'(1)));

endmodule

// File: rtl/lockdet_dp.sv
module lockdet_dp
  import lockdet_pkg::*;
#(
  parameter int LOCK_CODE_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  verdict_t               verdict,
  input  logic [LOCK_CODE_W-1:0] lockTime,
  input  logic                   latchMode,
  output logic                   lockFlag
);

  localparam int MAX_LOCK = 2 << ((1 << LOCK_CODE_W) - 1);
  localparam int CNT_W    = $clog2(MAX_LOCK + 2);

  logic [CNT_W-1:0] goodCnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] goodInc;

  assign target  = CNT_W'(2) << lockTime;
  assign goodInc = goodCnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt  <= '0;
      lockFlag <= 1'b0;
    end else if (verdict.goodStb) begin
      if (goodInc >= target) begin
        goodCnt  <= target;
        lockFlag <= 1'b1;
      end else begin
        goodCnt <= goodInc;
      end
    end else if (verdict.badStb) begin
      goodCnt <= '0;
      if (!latchMode) lockFlag <= 1'b0;
    end
  end

  // R2: the control never reports a good and a bad cycle together
  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({verdict.goodStb, verdict.badStb}));

  // R5: the flag can only rise on a good verdict
  p_rise_on_good_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(verdict.goodStb));

  // R6: a bad verdict leaves no good cycles counted
  p_bad_restarts_r6: assert property (@(posedge clk) disable iff (!rstN)
    verdict.badStb |=> (goodCnt == '0));

  // R7: in continuous mode a bad verdict drops the flag
  p_bad_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (verdict.badStb && !latchMode) |=> !lockFlag);

  // R8: in latching mode a set flag holds
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lockFlag && latchMode) |=> lockFlag);

endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
  import lockdet_pkg::*;
#(
  parameter int WIN_NARROW_TICKS = 3,
  parameter int WIN_WIDE_TICKS   = 6,
  parameter int LOCK_CODE_W      = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   refIn,
  input  logic                   fbIn,
  input  logic                   winSel,
  input  logic [LOCK_CODE_W-1:0] lockTime,
  input  logic                   latchMode,
  output logic                   lockFlag
);

  logic [1:0] riseBits;
  edge_t      edges;
  verdict_t   verdict;

  lockdet_edge #(.N(2)) i_edge (
    .clk     (clk),
    .rstN    (rstN),
    .pulseIn ({refIn, fbIn}),
    .riseOut (riseBits)
  );

  assign edges.refRise = riseBits[1];
  assign edges.fbRise  = riseBits[0];

  lockdet_ctrl #(
    .WIN_NARROW_TICKS (WIN_NARROW_TICKS),
    .WIN_WIDE_TICKS   (WIN_WIDE_TICKS)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .edges   (edges),
    .winSel  (winSel),
    .verdict (verdict)
  );

  lockdet_dp #(.LOCK_CODE_W(LOCK_CODE_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .verdict   (verdict),
    .lockTime  (lockTime),
    .latchMode (latchMode),
    .lockFlag  (lockFlag)
  );

endmodule

// File: tb/test_lockdet_top.sv
`timescale 1ns/1ps
module test_lockdet_top;

  localparam int NARROW = 3;
  localparam int WIDE   = 6;
  localparam int PERIOD = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refIn = 1'b0;
  logic       fbIn = 1'b0;
  logic       winSel = 1'b0;
  logic [1:0] lockTime = 2'b00;
  logic       latchMode = 1'b0;
  logic       lockFlag;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  lockdet_top i_lockdet_top (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn), .winSel(winSel),
    .lockTime(lockTime), .latchMode(latchMode), .lockFlag(lockFlag)
  );

  // Behavioural reference: pending-edge bookkeeping with integers
  int  mPend = 0;   // 0 none, 1 reference waiting, 2 feedback waiting
  int  mAge = 0;
  int  mGood = 0;
  bit  mFlag = 1'b0;
  bit  mPrevR = 1'b0;
  bit  mPrevF = 1'b0;

  always @(posedge clk) begin
    bit r, f;
    int win, need, verdictKind;
    if (!rstN) begin
      mPend = 0; mAge = 0; mGood = 0; mFlag = 1'b0; mPrevR = 1'b0; mPrevF = 1'b0;
    end else begin
      r = refIn && !mPrevR;
      f = fbIn && !mPrevF;
      mPrevR = refIn;
      mPrevF = fbIn;
      win  = winSel ? WIDE : NARROW;
      need = 2 ** (lockTime + 1);
      verdictKind = 0;
      if (mPend == 0) begin
        if (r && f) verdictKind = 1;
        else if (r) begin mPend = 1; mAge = 1; end
        else if (f) begin mPend = 2; mAge = 1; end
      end else if ((mPend == 1 && f) || (mPend == 2 && r)) begin
        verdictKind = 1; mPend = 0;
      end else if (mAge >= win) begin
        verdictKind = 2; mPend = 0;
      end else begin
        mAge++;
      end
      if (verdictKind == 1) begin
        mGood++;
        if (mGood >= need) begin mGood = need; mFlag = 1'b1; end
      end else if (verdictKind == 2) begin
        mGood = 0;
        if (!latchMode) mFlag = 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: lockFlag actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // R5 timing: flag compared with the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN) check("R5 per-clock model", lockFlag, mFlag);
  end

  // One reference period; feedback offset by skew cycles, or omitted
  task automatic refPeriod(input int skew, input bit dropFb);
    for (int t = 0; t < PERIOD; t++) begin
      refIn = (t == 4);
      fbIn  = !dropFb && (t == 4 + skew);
      @(negedge clk);
    end
  endtask

  task automatic goodPeriods(input int n, input int skew);
    for (int k = 0; k < n; k++) refPeriod(skew, 1'b0);
  endtask

  initial begin
    #500000;
    testsFailed++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", lockFlag, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R5, R2: code 00 needs two good periods; same-cycle edges are good
    goodPeriods(1, 0);
    check("R5 one short of count", lockFlag, 1'b0);
    goodPeriods(1, 0);
    check("R2 zero-skew lock", lockFlag, 1'b1);

    // R3, R7: narrow window, 4 ticks is outside and drops the flag
    refPeriod(NARROW + 1, 1'b0);
    check("R3 narrow over window", lockFlag, 1'b0);
    goodPeriods(2, NARROW);
    check("R3 narrow at window edge", lockFlag, 1'b1);

    // R4: missing feedback pulse
    refPeriod(0, 1'b1);
    check("R4 missing feedback", lockFlag, 1'b0);

    // R2: feedback before reference
    goodPeriods(2, -NARROW);
    check("R2 feedback leads", lockFlag, 1'b1);

    // R3: wide window
    winSel = 1'b1;
    refPeriod(WIDE + 1, 1'b0);
    check("R3 wide over window", lockFlag, 1'b0);
    goodPeriods(2, WIDE);
    check("R3 wide at window edge", lockFlag, 1'b1);

    // R5: each longer lock-time code, N-1 then N good periods
    for (int code = 1; code < 4; code++) begin
      lockTime = 2'(code);
      refPeriod(WIDE + 1, 1'b0);
      goodPeriods((2 << code) - 1, 2);
      check("R5 code N-1 periods", lockFlag, 1'b0);
      goodPeriods(1, 2);
      check("R5 code N periods", lockFlag, 1'b1);
    end

    // R6: bad period in mid-count restarts it (code 01, N=4)
    lockTime = 2'b01;
    refPeriod(0, 1'b1);
    goodPeriods(3, 1);
    refPeriod(WIDE + 2, 1'b0);
    goodPeriods(3, 1);
    check("R6 count restarted", lockFlag, 1'b0);
    goodPeriods(1, 1);
    check("R6 lock after fresh count", lockFlag, 1'b1);

    // R8: latching mode holds the flag
    lockTime = 2'b00;
    latchMode = 1'b1;
    refPeriod(WIDE + 1, 1'b0);
    check("R8 held through bad skew", lockFlag, 1'b1);
    refPeriod(0, 1'b1);
    check("R8 held through missing pulse", lockFlag, 1'b1);

    // R7: back to continuous, next bad period clears
    latchMode = 1'b0;
    goodPeriods(1, 0);
    check("R7 still set before bad", lockFlag, 1'b1);
    refPeriod(0, 1'b1);
    check("R7 continuous clears", lockFlag, 1'b0);

    // R1: reset in mid-lock clears and restarts the count
    goodPeriods(2, 0);
    check("R1 locked before reset", lockFlag, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears flag", lockFlag, 1'b0);
    rstN = 1'b1;
    goodPeriods(1, 0);
    check("R1 count restarted after reset", lockFlag, 1'b0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule